// File: doc/BRIEF.md
# Shared Transmit/Receive Descriptor Ring Controller

This block holds a single table of 128 buffer descriptors shared between a transmit ring and a receive ring. Entries below a programmable split count belong to transmit, and entries from the split count upward belong to receive. The controller keeps the current slot of each ring. It decides when a transmit may begin and works out how many bytes go on the wire and how many of them come from the buffer. When the datapath reports that a frame is finished, the controller updates the descriptor status, moves the ring index with the proper wrap rule and raises interrupt sources.

Host software writes descriptor words through a simple write port and can read any entry back at once. Every descriptor write requests a fresh transmit-start evaluation on the next clock. A rising transmit-enable also requests one. The datapath sees a one-cycle `tx_start` pulse together with the frame length and the copy length. It answers with `tx_done`. On the receive side it waits for `rx_allow`, then reports `rx_done` with the stored byte count. Moving the data itself, the MAC and the bus fabric all sit outside this block.

Top module: `ring_desc_ctrl`

## Requirements
- R1: After reset the transmit slot is 0, the receive slot is 64, the split count is 64, the minimum frame length is 0x40, the maximum frame length is 0x600, the interrupt sources are clear, `irq` is low and `tx_start` is low.
- R2: A transmit-start evaluation runs on the clock after a descriptor write, or after a rising `tx_enable`. `tx_start` pulses in the following cycle only when all of these hold: `tx_enable` is high, the split count is nonzero, bit 15 (ready) of the current transmit entry is set, and its length field [31:16] is greater than 4. While a frame is in flight, a pending evaluation waits until it completes.
- R3: The frame length equals the descriptor length, raised to the minimum frame length when bit 12 (pad) is set and the length is below that minimum. It is then capped at the maximum frame length unless `huge_enable` is high. The copy length is the smaller of the descriptor length and the frame length.
- R4: When a transmit completes, bit 15, bit 8 and bits [7:0] of its entry are cleared and every other bit is kept. A `tx_done` with no frame in flight changes nothing.
- R5: After a transmit completes, the transmit slot goes to 0 if bit 13 (wrap) of the entry is set. Otherwise it goes to slot+1, or to 0 when slot+1 reaches the split count.
- R6: `rx_allow` is high exactly when `rx_enable` is high, the split count is below 0x80, and bit 15 (empty) of the current receive entry is set.
- R7: An `rx_done` while `rx_allow` is high writes `rx_len` into [31:16] and clears bit 15 of the current receive entry. The slot then returns to the split count if bit 13 (wrap) is set or the slot is 127, and otherwise increments. An `rx_done` while `rx_allow` is low is ignored.
- R8: A rising `rx_enable` loads the receive slot with the split count. A rising `tx_enable` sets the transmit slot to 0 and requests a transmit-start evaluation.
- R9: A completed entry with bit 14 set raises source bit 0 (transmit) or source bit 2 (receive). Writing 1 to a source bit through the clear port clears it, and a same-cycle raise wins over the clear. `irq` is high whenever (sources AND mask) is nonzero.
- R10: A length-config write loads the minimum length from bits [31:16] and the maximum from [15:0]. A count write loads the 8-bit split count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| desc_we | input | 1 | Descriptor write strobe |
| desc_addr | input | 7 | Descriptor slot for write and read |
| desc_wdata | input | 32 | Descriptor write word |
| desc_rdata | output | 32 | Current content of slot `desc_addr` |
| cfg_len_we | input | 1 | Frame-length config write strobe |
| cfg_len_wdata | input | 32 | Minimum length [31:16], maximum length [15:0] |
| cfg_cnt_we | input | 1 | Split-count write strobe |
| cfg_cnt_wdata | input | 8 | New split count |
| tx_enable | input | 1 | Transmit enable level |
| rx_enable | input | 1 | Receive enable level |
| huge_enable | input | 1 | Disable the maximum-length cap on transmit |
| tx_start | output | 1 | One-cycle transmit start pulse |
| tx_slot | output | 7 | Current transmit slot |
| tx_frame_len | output | 16 | Bytes to send, held from the start pulse |
| tx_copy_len | output | 16 | Bytes taken from the buffer; the rest are zero |
| tx_done | input | 1 | Transmit completion event |
| rx_allow | output | 1 | Reception permitted into the current receive slot |
| rx_slot | output | 7 | Current receive slot |
| rx_done | input | 1 | Receive completion event |
| rx_len | input | 16 | Stored byte count for the completed receive |
| int_mask | input | 3 | Interrupt source mask |
| int_clr_we | input | 1 | Interrupt clear strobe |
| int_clr | input | 3 | Write-1-to-clear source bits |
| int_src | output | 3 | Interrupt sources (bit 0 transmit, bit 2 receive) |
| irq | output | 1 | Interrupt request |

## Verification
A wrong slot register appears within one completion. The next `tx_start` never comes or carries lengths from the wrong entry, and `rx_allow` follows the empty bit of the wrong slot. Read-back of the completed entry then shows status cleared in a slot the host never used. A faulty length path shows on `tx_frame_len` and `tx_copy_len` in the same cycle as the start pulse. A faulty source register shows on `int_src` and `irq` one clock after the completion or clear that should have moved it. The bench compares every completion against a full model of the table, so any stray write to the descriptor array is caught on a later read-back or start decision.

// File: rtl/ring_pkg.sv
package ring_pkg;
  // descriptor flag positions shared by both rings
  localparam int unsigned FLAG_OWN  = 15;
  localparam int unsigned FLAG_IRQ  = 14;
  localparam int unsigned FLAG_WRAP = 13;
  localparam int unsigned FLAG_PAD  = 12;
  localparam int unsigned FLAG_ERR  = 8;
  localparam int unsigned LEN_W     = 16;
  localparam int unsigned WORD_W    = 32;

  // interrupt source positions
  localparam int unsigned SRC_W  = 3;
  localparam int unsigned SRC_TX = 0;
  localparam int unsigned SRC_RX = 2;

  // reset defaults
  localparam int unsigned RST_MIN = 64;
  localparam int unsigned RST_MAX = 1536;
  localparam int unsigned RST_CNT = 64;

  typedef logic [WORD_W-1:0] desc_word_t;

  typedef struct packed {
    logic [LEN_W-1:0] len;
    logic             own;
    logic             irq;
    logic             wrap;
    logic             pad;
    logic [11:0]      stat;
  } tx_desc_t;
endpackage

// File: rtl/ring_desc_table.sv
module ring_desc_table
  import ring_pkg::*;
#(
  parameter int unsigned SLOTS = 128,
  parameter int unsigned IDX_W = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_we,
  input  logic [IDX_W-1:0] host_addr,
  input  desc_word_t       host_wdata,
  input  logic             tx_upd,
  input  logic [IDX_W-1:0] tx_slot,
  input  logic             rx_upd,
  input  logic [IDX_W-1:0] rx_slot,
  input  logic [LEN_W-1:0] rx_len,
  output desc_word_t       host_rdata,
  output desc_word_t       tx_word,
  output desc_word_t       rx_word
);
  desc_word_t words [SLOTS];

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    desc_word_t q;
    desc_word_t d;
    logic       en;

    always_comb begin
      d  = q;
      en = 1'b0;
      if (host_we && host_addr == IDX_W'(i)) begin
        d  = host_wdata;
        en = 1'b1;
      end
      // completion updates win over a same-cycle host write
      if (tx_upd && tx_slot == IDX_W'(i)) begin
        d[FLAG_OWN] = 1'b0;
        d[FLAG_ERR] = 1'b0;
        d[7:0]      = '0;
        en          = 1'b1;
      end
      if (rx_upd && rx_slot == IDX_W'(i)) begin
        d[WORD_W-1:LEN_W] = rx_len;
        d[FLAG_OWN]       = 1'b0;
        en                = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= d;
    end

    assign words[i] = q;
  end

  assign host_rdata = words[host_addr];
  assign tx_word    = words[tx_slot];
  assign rx_word    = words[rx_slot];

  AST_TX_DONE_CLEARS_OWN: assert property (@(posedge clk) disable iff (!rst_n)
    tx_upd |=> !words[$past(tx_slot)][FLAG_OWN]);  // R4
  AST_RX_DONE_STORES_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    rx_upd |=> words[$past(rx_slot)][WORD_W-1:LEN_W] == $past(rx_len));  // R7
endmodule

// File: rtl/ring_tx_ctrl.sv
module ring_tx_ctrl
  import ring_pkg::*;
#(
  parameter int unsigned IDX_W = 7,
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_enable,
  input  logic             huge_enable,
  input  logic [CNT_W-1:0] split_cnt,
  input  logic [LEN_W-1:0] min_len,
  input  logic [LEN_W-1:0] max_len,
  input  logic             kick,
  input  tx_desc_t         cur,
  input  logic             done,
  output logic [IDX_W-1:0] slot,
  output logic             start,
  output logic [LEN_W-1:0] frame_len,
  output logic [LEN_W-1:0] copy_len,
  output logic             upd,
  output logic             set_int
);
  logic             en_q, pend, busy;
  logic             rise, go;
  logic             pend_n, busy_n;
  logic [IDX_W-1:0] slot_n;
  logic [CNT_W-1:0] inc;
  logic [LEN_W-1:0] f_len, c_len;

  assign rise = tx_enable & ~en_q;
  assign upd  = done & busy;
  assign set_int = upd & cur.irq;

  // start decision on a pending evaluation
  assign go = pend & ~busy & ~rise & tx_enable & (split_cnt != '0) &
              cur.own & (cur.len > LEN_W'(4));

  always_comb begin
    f_len = cur.len;
    if (cur.pad && cur.len < min_len) f_len = min_len;
    if (!huge_enable && f_len > max_len) f_len = max_len;
    c_len = (cur.len < f_len) ? cur.len : f_len;
  end

  always_comb begin
    inc    = CNT_W'(slot) + CNT_W'(1);
    slot_n = slot;
    if (rise) begin
      slot_n = '0;
    end else if (upd) begin
      if (cur.wrap || inc >= split_cnt) slot_n = '0;
      else                              slot_n = inc[IDX_W-1:0];
    end
    pend_n = kick | rise | (pend & busy);
    busy_n = go | (busy & ~done);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      pend  <= 1'b0;
      busy  <= 1'b0;
      slot  <= '0;
      start <= 1'b0;
    end else begin
      en_q  <= tx_enable;
      pend  <= pend_n;
      busy  <= busy_n;
      slot  <= slot_n;
      start <= go;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_len <= '0;
      copy_len  <= '0;
    end else if (go) begin
      frame_len <= f_len;
      copy_len  <= c_len;
    end
  end

  AST_START_NEEDS_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> $past(tx_enable) && $past(pend));  // R2
  AST_FRAME_CAPPED: assert property (@(posedge clk) disable iff (!rst_n)
    start && !$past(huge_enable) |-> frame_len <= $past(max_len));  // R3
  AST_COPY_NOT_ABOVE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> copy_len <= frame_len);  // R3
  AST_TX_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    upd && cur.wrap |=> slot == '0);  // R5
endmodule

// File: rtl/ring_rx_ctrl.sv
module ring_rx_ctrl
  import ring_pkg::*;
#(
  parameter int unsigned SLOTS = 128,
  parameter int unsigned IDX_W = 7,
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_enable,
  input  logic [CNT_W-1:0] split_cnt,
  input  logic             cur_empty,
  input  logic             cur_irq,
  input  logic             cur_wrap,
  input  logic             done,
  output logic [IDX_W-1:0] slot,
  output logic             allow,
  output logic             upd,
  output logic             set_int
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(SLOTS - 1);

  logic             en_q, rise;
  logic [IDX_W-1:0] slot_n, base;

  assign base    = split_cnt[IDX_W-1:0];
  assign rise    = rx_enable & ~en_q;
  assign allow   = rx_enable & (split_cnt < CNT_W'(SLOTS)) & cur_empty;
  assign upd     = done & allow;
  assign set_int = upd & cur_irq;

  always_comb begin
    slot_n = slot;
    if (rise)                         slot_n = base;
    else if (upd && (cur_wrap || slot == LAST)) slot_n = base;
    else if (upd)                     slot_n = slot + IDX_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      slot <= IDX_W'(RST_CNT);
    end else begin
      en_q <= rx_enable;
      slot <= slot_n;
    end
  end

  AST_RX_LAST_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
    upd && !rise && slot == LAST |=> slot == $past(base));  // R7
  AST_RX_RISE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_enable) |=> slot == $past(base));  // R8
endmodule

// File: rtl/ring_irq.sv
module ring_irq
  import ring_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_set,
  input  logic             rx_set,
  input  logic             clr_we,
  input  logic [SRC_W-1:0] clr,
  input  logic [SRC_W-1:0] mask,
  output logic [SRC_W-1:0] src,
  output logic             irq
);
  logic [SRC_W-1:0] set_v, clr_v, src_n;

  always_comb begin
    set_v         = '0;
    set_v[SRC_TX] = tx_set;
    set_v[SRC_RX] = rx_set;
    clr_v         = clr_we ? clr : '0;
    src_n         = (src & ~clr_v) | set_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src <= '0;
    else        src <= src_n;
  end

  assign irq = |(src & mask);

  AST_TX_SOURCE_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
    tx_set |=> src[SRC_TX]);  // R9
  AST_TX_SOURCE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we && clr[SRC_TX] && !tx_set |=> !src[SRC_TX]);  // R9
endmodule

// File: rtl/ring_desc_ctrl.sv
module ring_desc_ctrl
  import ring_pkg::*;
#(
  parameter int unsigned SLOTS = 128,
  localparam int unsigned IDX_W = $clog2(SLOTS),
  localparam int unsigned CNT_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             desc_we,
  input  logic [IDX_W-1:0] desc_addr,
  input  logic [31:0]      desc_wdata,
  output logic [31:0]      desc_rdata,
  input  logic             cfg_len_we,
  input  logic [31:0]      cfg_len_wdata,
  input  logic             cfg_cnt_we,
  input  logic [CNT_W-1:0] cfg_cnt_wdata,
  input  logic             tx_enable,
  input  logic             rx_enable,
  input  logic             huge_enable,
  output logic             tx_start,
  output logic [IDX_W-1:0] tx_slot,
  output logic [15:0]      tx_frame_len,
  output logic [15:0]      tx_copy_len,
  input  logic             tx_done,
  output logic             rx_allow,
  output logic [IDX_W-1:0] rx_slot,
  input  logic             rx_done,
  input  logic [15:0]      rx_len,
  input  logic [2:0]       int_mask,
  input  logic             int_clr_we,
  input  logic [2:0]       int_clr,
  output logic [2:0]       int_src,
  output logic             irq
);
  logic [LEN_W-1:0] min_q, max_q;
  logic [CNT_W-1:0] cnt_q;
  desc_word_t       tx_word, rx_word;
  logic             tx_upd, rx_upd, tx_int, rx_int;
  logic             unused_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      min_q <= LEN_W'(RST_MIN);
      max_q <= LEN_W'(RST_MAX);
    end else if (cfg_len_we) begin
      min_q <= cfg_len_wdata[31:16];
      max_q <= cfg_len_wdata[15:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= CNT_W'(RST_CNT);
    else if (cfg_cnt_we) cnt_q <= cfg_cnt_wdata;
  end

  ring_desc_table #(.SLOTS(SLOTS), .IDX_W(IDX_W)) u_table (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_we    (desc_we),
    .host_addr  (desc_addr),
    .host_wdata (desc_wdata),
    .tx_upd     (tx_upd),
    .tx_slot    (tx_slot),
    .rx_upd     (rx_upd),
    .rx_slot    (rx_slot),
    .rx_len     (rx_len),
    .host_rdata (desc_rdata),
    .tx_word    (tx_word),
    .rx_word    (rx_word)
  );

  ring_tx_ctrl #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_tx (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_enable   (tx_enable),
    .huge_enable (huge_enable),
    .split_cnt   (cnt_q),
    .min_len     (min_q),
    .max_len     (max_q),
    .kick        (desc_we),
    .cur         (tx_desc_t'(tx_word)),
    .done        (tx_done),
    .slot        (tx_slot),
    .start       (tx_start),
    .frame_len   (tx_frame_len),
    .copy_len    (tx_copy_len),
    .upd         (tx_upd),
    .set_int     (tx_int)
  );

  ring_rx_ctrl #(.SLOTS(SLOTS), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_enable (rx_enable),
    .split_cnt (cnt_q),
    .cur_empty (rx_word[FLAG_OWN]),
    .cur_irq   (rx_word[FLAG_IRQ]),
    .cur_wrap  (rx_word[FLAG_WRAP]),
    .done      (rx_done),
    .slot      (rx_slot),
    .allow     (rx_allow),
    .upd       (rx_upd),
    .set_int   (rx_int)
  );

  ring_irq u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .tx_set (tx_int),
    .rx_set (rx_int),
    .clr_we (int_clr_we),
    .clr    (int_clr),
    .mask   (int_mask),
    .src    (int_src),
    .irq    (irq)
  );

  assign unused_bits = ^{rx_word[31:16], rx_word[FLAG_PAD:0]};
endmodule

// File: tb/tb_ring_desc_ctrl.sv
`timescale 1ns/1ps
module tb_ring_desc_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        desc_we;
  logic [6:0]  desc_addr;
  logic [31:0] desc_wdata, desc_rdata;
  logic        cfg_len_we, cfg_cnt_we;
  logic [31:0] cfg_len_wdata;
  logic [7:0]  cfg_cnt_wdata;
  logic        tx_enable, rx_enable, huge_enable;
  logic        tx_start, tx_done, rx_allow, rx_done;
  logic [6:0]  tx_slot, rx_slot;
  logic [15:0] tx_frame_len, tx_copy_len, rx_len;
  logic [2:0]  int_mask, int_clr, int_src;
  logic        int_clr_we, irq;

  always #2.5 clk = ~clk;

  ring_desc_ctrl dut (.*);

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  // reference model
  logic [31:0] tab [128];
  int          txi, rxi, cnt, mn, mx;
  bit          m_tx, m_rx, m_huge;
  logic [2:0]  src, mask;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic int f_frame(input logic [31:0] d);
    int l = int'(d[31:16]);
    if (d[12] && l < mn) l = mn;
    if (!m_huge && l > mx) l = mx;
    return l;
  endfunction

  function automatic int f_copy(input logic [31:0] d);
    int f = f_frame(d);
    int l = int'(d[31:16]);
    return (l < f) ? l : f;
  endfunction

  function automatic int f_tx_next(input int i, input logic [31:0] d);
    if (d[13]) return 0;
    if (i + 1 >= cnt) return 0;
    return (i + 1) % 128;
  endfunction

  function automatic int f_rx_next(input int i, input logic [31:0] d);
    if (d[13] || i == 127) return cnt % 128;
    return i + 1;
  endfunction

  task automatic read_chk(input int a, input string req);
    desc_addr = 7'(a);
    #1;
    chk(req, "entry readback", int'(desc_rdata), int'(tab[a]));
  endtask

  // called at the negedge right after the edge that set the request
  task automatic check_start();
    bit go;
    logic [31:0] d;
    int old;
    @(negedge clk);
    d  = tab[txi];
    go = m_tx && cnt != 0 && d[15] && d[31:16] > 16'd4;
    chk("R2", "tx_start", int'(tx_start), int'(go));
    if (go && tx_start) begin
      chk("R3", "frame length", int'(tx_frame_len), f_frame(d));
      chk("R3", "copy length", int'(tx_copy_len), f_copy(d));
      tx_done = 1'b1;
      @(negedge clk);
      tx_done = 1'b0;
      if (d[14]) src[0] = 1'b1;
      tab[txi] = d & ~32'h0000_81FF;
      old = txi;
      txi = f_tx_next(txi, d);
      read_chk(old, "R4");
      chk("R5", "tx slot", int'(tx_slot), txi);
      chk("R9", "sources", int'(int_src), int'(src));
      chk("R9", "irq", int'(irq), int'(|(src & mask)));
    end
  endtask

  task automatic wr_desc(input int a, input logic [31:0] d);
    @(negedge clk);
    desc_we = 1'b1; desc_addr = 7'(a); desc_wdata = d;
    @(negedge clk);
    desc_we = 1'b0;
    tab[a] = d;
    check_start();
  endtask

  task automatic set_tx(input bit v);
    bit r = v && !m_tx;
    @(negedge clk);
    tx_enable = v; m_tx = v;
    @(negedge clk);
    if (r) begin
      txi = 0;
      chk("R8", "tx slot after enable", int'(tx_slot), 0);
      check_start();
    end
  endtask

  task automatic set_rx(input bit v);
    bit r = v && !m_rx;
    @(negedge clk);
    rx_enable = v; m_rx = v;
    @(negedge clk);
    if (r) rxi = cnt % 128;
    chk("R8", "rx slot after enable", int'(rx_slot), rxi);
  endtask

  task automatic set_len(input int lo, input int hi);
    @(negedge clk);
    cfg_len_we = 1'b1; cfg_len_wdata = {16'(lo), 16'(hi)};
    @(negedge clk);
    cfg_len_we = 1'b0; mn = lo; mx = hi;
  endtask

  task automatic set_cnt(input int c);
    @(negedge clk);
    cfg_cnt_we = 1'b1; cfg_cnt_wdata = 8'(c);
    @(negedge clk);
    cfg_cnt_we = 1'b0; cnt = c;
  endtask

  task automatic do_rx(input int len, input logic [2:0] clr);
    bit al;
    logic [31:0] d;
    int old;
    @(negedge clk);
    d  = tab[rxi];
    al = m_rx && cnt < 128 && d[15];
    chk("R6", "rx_allow", int'(rx_allow), int'(al));
    rx_done = 1'b1; rx_len = 16'(len);
    if (clr != 3'b000) begin int_clr_we = 1'b1; int_clr = clr; end
    @(negedge clk);
    rx_done = 1'b0; int_clr_we = 1'b0; int_clr = '0;
    src = src & ~clr;
    old = rxi;
    if (al) begin
      if (d[14]) src[2] = 1'b1;
      tab[rxi] = {16'(len), 1'b0, d[14:0]};
      rxi = f_rx_next(rxi, d);
    end
    read_chk(old, "R7");
    chk("R7", "rx slot", int'(rx_slot), rxi);
    chk("R9", "sources after rx", int'(int_src), int'(src));
  endtask

  task automatic do_clr(input logic [2:0] b);
    @(negedge clk);
    int_clr_we = 1'b1; int_clr = b;
    @(negedge clk);
    int_clr_we = 1'b0; int_clr = '0;
    src = src & ~b;
    chk("R9", "sources after clear", int'(int_src), int'(src));
    chk("R9", "irq after clear", int'(irq), int'(|(src & mask)));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd91357));
    rst_n = 1'b0;
    desc_we = 0; desc_addr = 0; desc_wdata = 0;
    cfg_len_we = 0; cfg_len_wdata = 0; cfg_cnt_we = 0; cfg_cnt_wdata = 0;
    tx_enable = 0; rx_enable = 0; huge_enable = 0;
    tx_done = 0; rx_done = 0; rx_len = 0;
    int_mask = 0; int_clr_we = 0; int_clr = 0;
    for (int i = 0; i < 128; i++) tab[i] = '0;
    txi = 0; rxi = 64; cnt = 64; mn = 64; mx = 1536;
    m_tx = 0; m_rx = 0; m_huge = 0; src = 0; mask = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1", "tx slot", int'(tx_slot), 0);
    chk("R1", "rx slot", int'(rx_slot), 64);
    chk("R1", "sources", int'(int_src), 0);
    chk("R1", "irq", int'(irq), 0);
    chk("R1", "tx_start", int'(tx_start), 0);

    mask = 3'b101; int_mask = mask;
    set_tx(1'b1);
    // R1 default minimum via pad, R3, R4, R9
    wr_desc(0, {16'h0020, 16'hD1FF});
    chk("R1", "default min applied", int'(tx_frame_len), 16'h40);
    do_clr(3'b001);
    // R1 default maximum, then huge mode
    wr_desc(1, {16'h0800, 16'h8000});
    chk("R1", "default max applied", int'(tx_frame_len), 16'h600);
    @(negedge clk); huge_enable = 1; m_huge = 1;
    wr_desc(2, {16'h0800, 16'h8000});
    @(negedge clk); huge_enable = 0; m_huge = 0;
    // R2 length threshold and ready bit
    wr_desc(3, {16'h0004, 16'h8000});
    wr_desc(3, {16'h0005, 16'h8000});
    wr_desc(4, {16'h0040, 16'h0000});
    // R4 idle completion is ignored
    @(negedge clk); tx_done = 1;
    @(negedge clk); tx_done = 0;
    chk("R4", "idle done keeps slot", int'(tx_slot), txi);
    read_chk(txi, "R4");
    // R8 enable rise restarts at slot 0
    set_tx(1'b0);
    wr_desc(0, {16'h0030, 16'h8000});
    set_tx(1'b1);
    // R5 count wrap and flag wrap, R10 count write
    set_cnt(2);
    wr_desc(1, {16'h0030, 16'h8000});
    wr_desc(1, {16'h0030, 16'h8000});
    wr_desc(0, {16'h0030, 16'hA000});
    set_cnt(0);
    wr_desc(0, {16'h0030, 16'h8000});
    set_cnt(64);
    // R10 length write
    set_len(16'h0100, 16'h0200);
    wr_desc(txi, {16'h0010, 16'h9000});
    wr_desc(txi, {16'h0300, 16'h8000});

    // receive side
    set_rx(1'b1);
    do_rx(16'h50, 3'b000);
    wr_desc(64, {16'h0000, 16'hC000});
    do_rx(16'h77, 3'b000);
    set_cnt(126);
    set_rx(1'b0);
    set_rx(1'b1);
    wr_desc(126, {16'h0, 16'h8000});
    wr_desc(127, {16'h0, 16'h8000});
    do_rx(1, 3'b000);
    do_rx(2, 3'b000);
    wr_desc(126, {16'h0, 16'hE000});
    do_rx(3, 3'b100);
    set_cnt(128);
    wr_desc(rxi, {16'h0, 16'h8000});
    do_rx(4, 3'b000);
    set_cnt(64);
    set_rx(1'b0);
    set_rx(1'b1);
    do_clr(3'b111);

    // constrained random mix
    for (int it = 0; it < 400; it++) begin
      int op = int'($urandom % 10);
      logic [31:0] d;
      if (op < 4) begin
        d = $urandom;
        d[31:16] = 16'($urandom % 16'h700);
        d[15] = ($urandom % 4) != 0;
        d[13] = ($urandom % 4) == 0;
        @(negedge clk); m_huge = ($urandom % 4) == 0; huge_enable = m_huge;
        wr_desc(txi, d);
      end else if (op < 7) begin
        if ($urandom % 3 != 0) begin
          d = $urandom;
          d[15] = ($urandom % 5) != 0;
          d[13] = ($urandom % 6) == 0;
          wr_desc(rxi, d);
        end
        do_rx(int'($urandom % 16'h800), 3'($urandom % 8) & 3'b101);
      end else if (op == 7) begin
        set_len(int'($urandom % 16'h80), 16'h20 + int'($urandom % 16'h700));
        if ($urandom % 2 == 0) set_cnt(1 + int'($urandom % 128));
      end else if (op == 8) begin
        @(negedge clk); mask = 3'($urandom); int_mask = mask;
        do_clr(3'($urandom));
      end else begin
        if ($urandom % 2 == 0) set_tx(~m_tx);
        else                   set_rx(~m_rx);
      end
    end

    finished = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule